// File: doc/BRIEF.md
# Packed Quad Byte Multiply Unit

This execution unit runs one packed multiply instruction. It splits a 32-bit instruction word into fields and reads two source words from a 16-entry register file that it owns. It then forms four byte-by-byte products in parallel and writes them back as two 32-bit words to two destinations, which are addressed separately. A mode field picks one of two modes. In the first, both operands are treated as unsigned bytes. In the second, the bytes of the first source are signed and the bytes of the second source stay unsigned.

The register file also has a fill port. Other execution units that share the file use it to deposit values. The unit's own write-back takes priority over the fill port. A result is written to the file on the clock edge that follows an accepted instruction. On that same edge the result appears on the registered write-back outputs, where it stays for one cycle with its strobes raised.

Top module: `pbmul_unit`

## Requirements
- R1: The first source index is instruction bits [13:10] and the second source index is bits [17:14]. The upper-half destination index is bits [9:6] and the lower-half destination index is bits [21:18].
- R2: Mode bits [25:22] equal to 4'h2 select the mixed mode. Every other value selects the fully unsigned mode.
- R3: In unsigned mode, lane i (i = 0..3, byte 0 least significant) multiplies byte i of the first source by byte i of the second source, both zero-extended. The result keeps the low 16 bits of the product.
- R4: In mixed mode each byte of the first source is sign-extended and each byte of the second source is zero-extended. The lane result is the low 16 bits of the two's-complement product, which lies between -32640 and 32385.
- R5: The lower-half destination word is {lane1, lane0}, with lane1 in bits [31:16]. The upper-half destination word is {lane3, lane2}.
- R6: Both write strobes rise together in the cycle after `valid_i` is sampled high. They stay high for exactly one cycle per accepted instruction and are low otherwise.
- R7: Both result words are stored in the register file on the edge that accepts the instruction, so any later instruction reads them as sources.
- R8: When both destination indices are equal, the stored word is the upper-half word {lane3, lane2}.
- R9: A fill write stores `fill_data_i` at `fill_idx_i` on the clock edge. If a write-back targets the same index on that edge, the write-back value wins.
- R10: While reset is asserted, and after it is released, the strobes are low, the write-back outputs are zero and every register file entry reads as zero.
- R11: When no instruction is accepted, the write-back data and index outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| fill_en_i | input | 1 | Fill write strobe from a sharing unit |
| fill_idx_i | input | 4 | Fill write index |
| fill_data_i | input | 32 | Fill write data |
| wb_hi_en_o | output | 1 | Upper-half write strobe |
| wb_hi_idx_o | output | 4 | Upper-half destination index |
| wb_hi_data_o | output | 32 | Word {lane3, lane2} |
| wb_lo_en_o | output | 1 | Lower-half write strobe |
| wb_lo_idx_o | output | 4 | Lower-half destination index |
| wb_lo_data_o | output | 32 | Word {lane1, lane0} |

## Verification
Two kinds of write can hit the same register file entry on one edge. The first case is the two destination fields of a single instruction pointing at the same index. The second is a fill write landing on a destination of the instruction being accepted. The bench provokes both with directed instructions, and with random destination indices drawn from a narrow range so that collisions recur. It judges the outcome through later instructions that read the contested entry and multiply it by a word of byte-wise ones, which brings every stored byte back out on the write-back ports.

// File: rtl/pbmul_pkg.sv
package pbmul_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PROD_W    = 2 * BYTE_W;
  localparam int unsigned LANES     = XLEN / BYTE_W;
  localparam int unsigned HALF_LN   = LANES / 2;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned NREG      = 1 << IDX_W;
  localparam int unsigned MODE_W    = 4;
  localparam logic [MODE_W-1:0] MODE_MIXED = 4'h2;

  localparam int unsigned F_DHI_LSB = 6;
  localparam int unsigned F_SA_LSB  = 10;
  localparam int unsigned F_SB_LSB  = 14;
  localparam int unsigned F_DLO_LSB = 18;
  localparam int unsigned F_MODE_LSB = 22;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [XLEN-1:0]  word_t;
  typedef logic [PROD_W-1:0] prod_t;

  typedef struct packed {
    idx_t src_a;
    idx_t src_b;
    idx_t dst_hi;
    idx_t dst_lo;
    logic mixed;
  } dec_t;
endpackage

// File: rtl/pbmul_rst_sync.sv
module pbmul_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pbmul_decode.sv
module pbmul_decode
  import pbmul_pkg::*;
(
  input  word_t instr,
  output dec_t  dec
);
  always_comb begin
    dec.dst_hi = instr[F_DHI_LSB +: IDX_W];
    dec.src_a  = instr[F_SA_LSB  +: IDX_W];
    dec.src_b  = instr[F_SB_LSB  +: IDX_W];
    dec.dst_lo = instr[F_DLO_LSB +: IDX_W];
    dec.mixed  = (instr[F_MODE_LSB +: MODE_W] == MODE_MIXED);
  end
endmodule

// File: rtl/pbmul_lane.sv
module pbmul_lane #(
  parameter int unsigned IN_W = 8
) (
  input  logic [IN_W-1:0]   a,
  input  logic [IN_W-1:0]   b,
  input  logic              mixed,
  output logic [2*IN_W-1:0] prod
);
  logic signed [IN_W:0]     a_ext;
  logic signed [IN_W:0]     b_ext;
  logic signed [2*IN_W+1:0] full;

  always_comb begin
    a_ext = $signed({mixed & a[IN_W-1], a});
    b_ext = $signed({1'b0, b});
    full  = a_ext * b_ext;
    prod  = full[2*IN_W-1:0];
  end
endmodule

// File: rtl/pbmul_regfile.sv
module pbmul_regfile
  import pbmul_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  idx_t  ra_idx,
  output word_t ra_data,
  input  idx_t  rb_idx,
  output word_t rb_data,
  input  logic  hi_we,
  input  idx_t  hi_idx,
  input  word_t hi_data,
  input  logic  lo_we,
  input  idx_t  lo_idx,
  input  word_t lo_data,
  input  logic  fill_we,
  input  idx_t  fill_idx,
  input  word_t fill_data
);
  word_t mem_q [NREG];
  word_t mem_d [NREG];

  always_comb begin
    for (int unsigned k = 0; k < NREG; k++) begin
      mem_d[k] = mem_q[k];
      if (fill_we && fill_idx == idx_t'(k)) mem_d[k] = fill_data;
      if (lo_we   && lo_idx   == idx_t'(k)) mem_d[k] = lo_data;
      if (hi_we   && hi_idx   == idx_t'(k)) mem_d[k] = hi_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned k = 0; k < NREG; k++) mem_q[k] <= '0;
    end else begin
      for (int unsigned k = 0; k < NREG; k++) mem_q[k] <= mem_d[k];
    end
  end

  assign ra_data = mem_q[ra_idx];
  assign rb_data = mem_q[rb_idx];
endmodule

// File: rtl/pbmul_unit.sv
module pbmul_unit
  import pbmul_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [31:0] instr_i,
  input  logic        fill_en_i,
  input  logic [3:0]  fill_idx_i,
  input  logic [31:0] fill_data_i,
  output logic        wb_hi_en_o,
  output logic [3:0]  wb_hi_idx_o,
  output logic [31:0] wb_hi_data_o,
  output logic        wb_lo_en_o,
  output logic [3:0]  wb_lo_idx_o,
  output logic [31:0] wb_lo_data_o
);
  logic  rst_sync_n;
  dec_t  dec;
  word_t rd_a;
  word_t rd_b;
  prod_t lane_prod [LANES];
  word_t hi_word_d;
  word_t lo_word_d;

  logic  hi_en_q, lo_en_q;
  idx_t  hi_idx_q, lo_idx_q, hi_idx_d, lo_idx_d;
  word_t hi_data_q, lo_data_q, hi_data_d, lo_data_d;

  pbmul_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pbmul_decode u_dec (.instr(instr_i), .dec(dec));

  pbmul_regfile u_rf (
    .clk(clk), .rst_n(rst_sync_n),
    .ra_idx(dec.src_a), .ra_data(rd_a),
    .rb_idx(dec.src_b), .rb_data(rd_b),
    .hi_we(valid_i), .hi_idx(dec.dst_hi), .hi_data(hi_word_d),
    .lo_we(valid_i), .lo_idx(dec.dst_lo), .lo_data(lo_word_d),
    .fill_we(fill_en_i), .fill_idx(fill_idx_i), .fill_data(fill_data_i)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pbmul_lane #(.IN_W(BYTE_W)) u_lane (
      .a    (rd_a[l*BYTE_W +: BYTE_W]),
      .b    (rd_b[l*BYTE_W +: BYTE_W]),
      .mixed(dec.mixed),
      .prod (lane_prod[l])
    );
    if (l < HALF_LN) begin : g_lo
      assign lo_word_d[l*PROD_W +: PROD_W] = lane_prod[l];
    end else begin : g_hi
      assign hi_word_d[(l-HALF_LN)*PROD_W +: PROD_W] = lane_prod[l];
    end
  end

  always_comb begin
    hi_idx_d  = hi_idx_q;
    lo_idx_d  = lo_idx_q;
    hi_data_d = hi_data_q;
    lo_data_d = lo_data_q;
    if (valid_i) begin
      hi_idx_d  = dec.dst_hi;
      lo_idx_d  = dec.dst_lo;
      hi_data_d = hi_word_d;
      lo_data_d = lo_word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hi_en_q   <= 1'b0;
      lo_en_q   <= 1'b0;
      hi_idx_q  <= '0;
      lo_idx_q  <= '0;
      hi_data_q <= '0;
      lo_data_q <= '0;
    end else begin
      hi_en_q   <= valid_i;
      lo_en_q   <= valid_i;
      hi_idx_q  <= hi_idx_d;
      lo_idx_q  <= lo_idx_d;
      hi_data_q <= hi_data_d;
      lo_data_q <= lo_data_d;
    end
  end

  assign wb_hi_en_o   = hi_en_q;
  assign wb_lo_en_o   = lo_en_q;
  assign wb_hi_idx_o  = hi_idx_q;
  assign wb_lo_idx_o  = lo_idx_q;
  assign wb_hi_data_o = hi_data_q;
  assign wb_lo_data_o = lo_data_q;
endmodule

// File: rtl/pbmul_unit_chk.sv
module pbmul_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic [31:0] instr_i,
  input logic [31:0] rd_b,
  input logic        wb_hi_en_o,
  input logic [3:0]  wb_hi_idx_o,
  input logic [31:0] wb_hi_data_o,
  input logic        wb_lo_en_o,
  input logic [3:0]  wb_lo_idx_o,
  input logic [31:0] wb_lo_data_o
);
  AST_STROBES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_hi_en_o == wb_lo_en_o); // R6

  AST_STROBE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> wb_hi_en_o); // R6

  AST_STROBE_ONLY_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !wb_hi_en_o); // R6

  AST_HI_DEST_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> wb_hi_idx_o == $past(instr_i[9:6])); // R1

  AST_LO_DEST_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> wb_lo_idx_o == $past(instr_i[21:18])); // R1

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && rd_b == 32'h0) |=> (wb_hi_data_o == 32'h0 && wb_lo_data_o == 32'h0)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(wb_hi_data_o) && $stable(wb_lo_data_o)
                  && $stable(wb_hi_idx_o) && $stable(wb_lo_idx_o))); // R11
endmodule

bind pbmul_unit pbmul_unit_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .valid_i(valid_i), .instr_i(instr_i),
  .rd_b(rd_b),
  .wb_hi_en_o(wb_hi_en_o), .wb_hi_idx_o(wb_hi_idx_o), .wb_hi_data_o(wb_hi_data_o),
  .wb_lo_en_o(wb_lo_en_o), .wb_lo_idx_o(wb_lo_idx_o), .wb_lo_data_o(wb_lo_data_o)
);

// File: tb/pbmul_unit_tb.sv
`timescale 1ns/1ps
module pbmul_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [31:0] instr_i;
  logic        fill_en_i;
  logic [3:0]  fill_idx_i;
  logic [31:0] fill_data_i;
  logic        wb_hi_en_o, wb_lo_en_o;
  logic [3:0]  wb_hi_idx_o, wb_lo_idx_o;
  logic [31:0] wb_hi_data_o, wb_lo_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [16];

  always #2.5 clk = ~clk;

  pbmul_unit u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .fill_en_i(fill_en_i), .fill_idx_i(fill_idx_i), .fill_data_i(fill_data_i),
    .wb_hi_en_o(wb_hi_en_o), .wb_hi_idx_o(wb_hi_idx_o), .wb_hi_data_o(wb_hi_data_o),
    .wb_lo_en_o(wb_lo_en_o), .wb_lo_idx_o(wb_lo_idx_o), .wb_lo_data_o(wb_lo_data_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_ref(logic [7:0] a, logic [7:0] b, bit mixed);
    int sa = mixed ? int'($signed(a)) : int'(a);
    int r  = sa * int'(b);
    return r[15:0];
  endfunction

  function automatic logic [31:0] mk(int unsigned mode, int unsigned dlo, int unsigned sb,
                                     int unsigned sa, int unsigned dhi);
    logic [31:0] w = $urandom;
    w[25:22] = mode[3:0]; w[21:18] = dlo[3:0]; w[17:14] = sb[3:0];
    w[13:10] = sa[3:0];   w[9:6]   = dhi[3:0];
    return w;
  endfunction

  // Issue one instruction, optionally with a fill on the same edge; check results.
  task automatic issue(logic [31:0] ins, bit fe, int unsigned fidx, logic [31:0] fdat, string req);
    logic [31:0] a, b, lo, hi;
    bit mixed;
    @(negedge clk);
    valid_i = 1'b1; instr_i = ins;
    fill_en_i = fe; fill_idx_i = fidx[3:0]; fill_data_i = fdat;
    a = model[ins[13:10]]; b = model[ins[17:14]];
    mixed = (ins[25:22] == 4'h2);
    for (int l = 0; l < 2; l++) begin
      lo[l*16 +: 16] = lane_ref(a[l*8 +: 8],     b[l*8 +: 8],     mixed);
      hi[l*16 +: 16] = lane_ref(a[(l+2)*8 +: 8], b[(l+2)*8 +: 8], mixed);
    end
    if (fe) model[fidx] = fdat;
    model[ins[21:18]] = lo;
    model[ins[9:6]]   = hi;
    @(posedge clk); #1;
    check({req, " R6 strobes"}, {wb_hi_en_o, wb_lo_en_o}, 2'b11);
    check({req, " R1 idx"}, {wb_hi_idx_o, wb_lo_idx_o}, {ins[9:6], ins[21:18]});
    check({req, " R5 data"}, {wb_hi_data_o, wb_lo_data_o}, {hi, lo});
    @(negedge clk);
    valid_i = 1'b0; fill_en_i = 1'b0;
    @(posedge clk); #1;
    check("R6 strobes drop", {wb_hi_en_o, wb_lo_en_o}, 2'b00);
    check("R11 hold", {wb_hi_data_o, wb_lo_data_o}, {hi, lo});
  endtask

  task automatic fill(int unsigned idx, logic [31:0] dat);
    @(negedge clk);
    fill_en_i = 1'b1; fill_idx_i = idx[3:0]; fill_data_i = dat;
    model[idx] = dat;
    @(negedge clk);
    fill_en_i = 1'b0;
  endtask

  // Read register idx back via a multiply by byte-wise ones held in entry 15.
  task automatic readback(int unsigned idx, string req);
    logic [31:0] v = model[idx];
    issue(mk(0, 12, 15, idx, 13), 0, 0, 0, req);
    check({req, " readback"}, {wb_hi_data_o, wb_lo_data_o},
          {8'h0, v[31:24], 8'h0, v[23:16], 8'h0, v[15:8], 8'h0, v[7:0]});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 16; k++) model[k] = '0;
    valid_i = 0; instr_i = 0; fill_en_i = 0; fill_idx_i = 0; fill_data_i = 0;
    rst_n = 0;
    repeat (3) @(posedge clk); #1;
    check("R10 reset outputs", {wb_hi_en_o, wb_lo_en_o, wb_hi_data_o, wb_lo_data_o},
          {2'b00, 64'h0});
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk); #1;
    check("R10 after release", {wb_hi_en_o, wb_lo_en_o, wb_hi_idx_o, wb_lo_idx_o}, 10'h0);
    // R10: registers start at zero
    issue(mk(0, 1, 3, 2, 0), 0, 0, 0, "R10 zero regfile");

    fill(15, 32'h0101_0101);
    // R3 corner: max unsigned
    fill(1, 32'hFFFF_FFFF); fill(2, 32'hFFFF_FFFF);
    issue(mk(5, 3, 2, 1, 4), 0, 0, 0, "R3 max unsigned");
    // R4 mixed extremes: -128*255, 127*255, -1*1
    fill(1, 32'h807F_FF80); fill(2, 32'hFFFF_01FF);
    issue(mk(2, 3, 2, 1, 4), 0, 0, 0, "R4 mixed extremes");
    // R2: mode 3 is unsigned, same operands
    issue(mk(3, 3, 2, 1, 4), 0, 0, 0, "R2 non-mixed mode");
    // R5 lane ordering with distinct bytes
    fill(5, 32'h0403_0201); fill(6, 32'h1110_0F0E);
    issue(mk(0, 7, 6, 5, 8), 0, 0, 0, "R5 lane order");
    // R7 result reused as a source
    readback(8, "R7 hi stored");
    readback(7, "R7 lo stored");
    // R8 equal destinations
    issue(mk(0, 9, 6, 5, 9), 0, 0, 0, "R8 collide");
    readback(9, "R8 hi wins");
    // R9 fill vs write-back on the same index, and fill to another index
    issue(mk(2, 10, 6, 1, 11), 1, 10, 32'hDEAD_BEEF, "R9 wb over fill");
    readback(10, "R9 wb wins");
    issue(mk(0, 10, 6, 1, 11), 1, 3, 32'hCAFE_F00D, "R9 fill other");
    readback(3, "R9 fill stored");

    // Random traffic, destinations in 0..11 to provoke collisions
    for (int k = 0; k < 16; k++) fill(k % 12, $urandom);
    for (int n = 0; n < 300; n++) begin
      int unsigned mode = ($urandom % 3 == 0) ? 2 : $urandom % 16;
      issue(mk(mode, $urandom % 12, $urandom % 12, $urandom % 12, $urandom % 12),
            ($urandom % 4 == 0), $urandom % 12, $urandom,
            (mode == 2) ? "R4 random" : "R3 random");
    end
    for (int k = 0; k < 12; k++) readback(k, "R7 random final");

    done = 1;
    finish_run();
  end
endmodule